// File: doc/BRIEF.md
# Sector Hamming Parity Generator

This block computes a single-error-correcting Hamming code over one 512-byte flash sector while the sector's bytes pass over an 8-bit data path. Each data bit has a 12-bit index: its byte address within the sector (9 bits) above its bit position within the byte (3 bits). For every index bit the block keeps two parities. One covers all data bits whose index has that bit set. The other covers all data bits whose index has that bit clear. The result is a 24-bit code word that is ready to be written into three spare-area bytes.

A write or read path pulses `start` at the beginning of a sector and then presents bytes with `din_valid`. After the 512th byte the block raises `done` for one cycle and holds the code until the next `start`. The code is stored inverted. An erased sector, which reads as all ones, therefore carries a code that agrees with the all-ones spare bytes next to it. Comparing the stored code with a freshly computed one, and correcting the error, are left to a separate block.

Top module: `ecc_hamming_gen`

## Requirements
- R1: After reset, `code` is 24'hFFFFFF and `done` is 0.
- R2: A `start` pulse clears the accumulated parity. In the cycle after it, `code` is 24'hFFFFFF and `done` is 0, and the next accepted byte is byte address 0 of a new sector. This also holds when `start` arrives in the middle of a sector.
- R3: Bit i of the byte at address A has index {A[8:0], i[2:0]}. Bit k of the upper field, `code[12+k]`, is the inverse of the XOR of every data bit whose index bit k is 1.
- R4: Bit k of the lower field, `code[k]`, is the inverse of the XOR of every data bit whose index bit k is 0. A single 1 bit at index X in an otherwise zero sector therefore gives `code` = {~X, X}. The spare bytes take `code[7:0]` first, then `code[15:8]`, then `code[23:16]`.
- R5: A sector of 512 bytes of 8'hFF gives `code` = 24'hFFFFFF.
- R6: `done` is 1 for exactly one cycle. That cycle is the one that follows the clock edge that accepts the 512th byte.
- R7: Once 512 bytes have been accepted, further `din_valid` bytes are ignored until the next `start`. `code` does not change and `done` stays 0.
- R8: When `start` and `din_valid` are high in the same cycle, `start` wins. The byte is discarded and is not counted.
- R9: Idle cycles between bytes have no effect. `code` reflects each accepted byte in the cycle after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the parity and begins a new sector |
| din_valid | input | 1 | `din` holds a sector byte this cycle |
| din | input | 8 | Sector data byte |
| code | output | 24 | Inverted parity code; upper field in 23:12, lower field in 11:0 |
| done | output | 1 | One-cycle pulse after the last byte of the sector |

## Verification
Each result sits one register after its stimulus. The code, the clearing by `start` and the `done` pulse all appear in the cycle after the clock edge that samples the byte or the start. The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a cycle after the edge that captured them. Expected codes come from a model in the bench that walks every data bit and XORs its full 12-bit index into the upper set and the index's complement into the lower set. It does not use the row and column split that the design uses. The `done` pulse is checked at the falling edge right after the 512th byte is captured, and checked low one cycle later.

// File: rtl/ecc_hm_pkg.sv
package ecc_hm_pkg;
  typedef enum logic {
    SEC_FILL = 1'b0,
    SEC_FULL = 1'b1
  } sec_state_t;
endpackage

// File: rtl/ecc_byte_contrib.sv
module ecc_byte_contrib #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int IDX_W = ADDR_W + BIT_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [IDX_W-1:0]  hi_par,
  output logic [IDX_W-1:0]  lo_par
);
  // mask of data bit positions whose position bit j equals sel
  function automatic logic [DATA_W-1:0] col_mask(input int j, input logic sel);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (((i >> j) & 1) == int'(sel));
    return m;
  endfunction

  logic row_par;
  assign row_par = ^data;

  for (genvar j = 0; j < BIT_W; j++) begin : g_col
    assign hi_par[j] = ^(data & col_mask(j, 1'b1));
    assign lo_par[j] = ^(data & col_mask(j, 1'b0));
  end

  for (genvar a = 0; a < ADDR_W; a++) begin : g_row
    assign hi_par[BIT_W+a] = row_par &  addr[a];
    assign lo_par[BIT_W+a] = row_par & ~addr[a];
  end

  // every set data bit lands in exactly one of the two sets per index bit
  always_comb begin
    for (int k = 0; k < IDX_W; k++)
      assert ((hi_par[k] ^ lo_par[k]) == row_par)
        else $error("p_split_consistent_r3: index bit %0d", k);
  end
endmodule

// File: rtl/ecc_sector_ctrl.sv
module ecc_sector_ctrl
  import ecc_hm_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              din_valid,
  output logic              accept,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SECTOR_BYTES - 1);

  sec_state_t       state;
  logic [ADDR_W-1:0] count;
  logic             last_byte;

  assign accept    = din_valid && !start && (state == SEC_FILL);
  assign last_byte = accept && (count == LAST_ADDR);
  assign addr      = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEC_FILL;
      count <= '0;
      done  <= 1'b0;
    end else if (start) begin
      state <= SEC_FILL;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_byte;
      if (accept) begin
        count <= count + ADDR_W'(1);
        if (last_byte) state <= SEC_FULL;
      end
    end
  end

  p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == SEC_FULL));
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEC_FULL) |-> !accept);
  p_start_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !accept);
  p_start_rewinds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0) && (state == SEC_FILL));
endmodule

// File: rtl/ecc_hamming_gen.sv
module ecc_hamming_gen #(
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(SECTOR_BYTES),
  localparam int BIT_W = $clog2(DATA_W),
  localparam int IDX_W = ADDR_W + BIT_W,
  localparam int CODE_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din,
  output logic [CODE_W-1:0] code,
  output logic              done
);
  logic              accept;
  logic [ADDR_W-1:0] byte_addr;
  logic [IDX_W-1:0]  hi_par;
  logic [IDX_W-1:0]  lo_par;
  logic [CODE_W-1:0] acc;

  ecc_sector_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid),
    .accept(accept), .addr(byte_addr), .done(done)
  );

  ecc_byte_contrib #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_contrib (
    .addr(byte_addr), .data(din), .hi_par(hi_par), .lo_par(lo_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (start)  acc <= '0;
    else if (accept) acc <= acc ^ {hi_par, lo_par};
  end

  // stored inverted so an erased sector matches its all-ones spare bytes
  assign code = ~acc;

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (code == '1) && !done);
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start) |=> $stable(code));
  p_ignored_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && din_valid && !start) |=> $stable(code));
endmodule

// File: tb/tb_ecc_hamming_gen.sv
module tb_ecc_hamming_gen;
  localparam int SECTOR = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        din_valid = 1'b0;
  logic [7:0]  din = '0;
  logic [23:0] code;
  logic        done;

  int tests = 0;
  int fails = 0;
  logic [7:0] mem [SECTOR];

  always #5 clk = ~clk;

  ecc_hamming_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid),
    .din(din), .code(code), .done(done)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  // every set bit XORs its whole index into the upper set, its complement into the lower
  function automatic logic [23:0] model(input int n);
    logic [11:0] p1 = '0;
    logic [11:0] p0 = '0;
    for (int a = 0; a < n; a++)
      for (int b = 0; b < 8; b++)
        if (mem[a][b]) begin
          p1 ^= 12'((a << 3) | b);
          p0 ^= ~12'((a << 3) | b);
        end
    return ~{p1, p0};
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 code cleared", code, 24'hFFFFFF);
    chk("R2 done low", {23'd0, done}, 24'd0);
  endtask

  task automatic feed_sector(input bit gap);
    for (int i = 0; i < SECTOR; i++) begin
      @(negedge clk);
      din_valid = 1'b1; din = mem[i];
      if (gap && (i % 4 == 2)) begin
        @(negedge clk); din_valid = 1'b0;
      end
    end
    @(negedge clk); din_valid = 1'b0;
    chk("R6 done after 512th byte", {23'd0, done}, 24'd1);
    @(negedge clk);
    chk("R6 done one cycle", {23'd0, done}, 24'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset code", code, 24'hFFFFFF);
    chk("R1 reset done", {23'd0, done}, 24'd0);
  endtask

  task automatic t_single_bit(input int a, input int b, input logic [23:0] exp);
    for (int i = 0; i < SECTOR; i++) mem[i] = 8'h00;
    mem[a][b] = 1'b1;
    do_start();
    feed_sector(1'b0);
    chk("R3 R4 single bit code", code, exp);
    chk("R3 R4 single bit model", code, model(SECTOR));
  endtask

  task automatic t_erased();
    for (int i = 0; i < SECTOR; i++) mem[i] = 8'hFF;
    do_start();
    feed_sector(1'b0);
    chk("R5 erased sector", code, 24'hFFFFFF);
  endtask

  task automatic t_random(input logic [15:0] seed);
    logic [15:0] lf = seed;
    for (int i = 0; i < SECTOR; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem[i] = lf[7:0] ^ lf[15:8];
    end
    do_start();
    feed_sector(1'b1);
    chk("R9 R3 random sector with gaps", code, model(SECTOR));
  endtask

  task automatic t_partial();
    for (int i = 0; i < SECTOR; i++) mem[i] = 8'h00;
    mem[0] = 8'h01; mem[1] = 8'h80;
    do_start();
    @(negedge clk); din_valid = 1'b1; din = mem[0];
    @(negedge clk); din_valid = 1'b0;
    chk("R9 first byte visible", code, 24'hFFF000);
    @(negedge clk);
    chk("R9 idle holds code", code, 24'hFFF000);
    din_valid = 1'b1; din = mem[1];
    @(negedge clk); din_valid = 1'b0;
    chk("R9 second byte visible", code, model(2));
  endtask

  task automatic t_overflow();
    logic [23:0] held;
    held = code;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); din_valid = 1'b1; din = 8'(8'h3C + i * 17);
    end
    @(negedge clk); din_valid = 1'b0;
    chk("R7 code unchanged after full", code, held);
    chk("R7 done stays low", {23'd0, done}, 24'd0);
  endtask

  task automatic t_start_priority();
    for (int i = 0; i < SECTOR; i++) mem[i] = 8'(i * 7 + 3);
    @(negedge clk); start = 1'b1; din_valid = 1'b1; din = 8'hA5;
    @(negedge clk); start = 1'b0; din_valid = 1'b0;
    chk("R8 byte with start dropped", code, 24'hFFFFFF);
    feed_sector(1'b0);
    chk("R8 sector after start", code, model(SECTOR));
  endtask

  task automatic t_mid_restart();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); din_valid = 1'b1; din = 8'(i ^ 8'h5A);
    end
    @(negedge clk); din_valid = 1'b0;
    do_start();
    for (int i = 0; i < SECTOR; i++) mem[i] = 8'(i ^ (i >> 3));
    feed_sector(1'b0);
    chk("R2 restart mid sector", code, model(SECTOR));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_bit(0, 0, 24'hFFF000);
    t_single_bit(511, 7, 24'h000FFF);
    t_single_bit(300, 5, 24'h69A965);
    t_erased();
    t_overflow();
    t_random(16'hACE1);
    t_partial();
    t_start_priority();
    t_mid_restart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule